// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Per-Pin Interrupt Styles

The block gives software control of sixteen general-purpose pins through a simple 32-bit register bus. Each pin can be driven from an output data bit or left as an input, and the current pin levels can be read back after they pass through a two-flop synchronizer. Each pin also holds a 3-bit interrupt style. The style selects one of five ways to raise a sticky pending flag: active-high level, active-low level, rising edge, falling edge, or any transition. Software clears a pending flag by writing a 1 to its status bit.

Pins 0 to 12 each drive a dedicated active-high interrupt line to the processor. Pins 13 to 15 record events in the status register only. Every pin has a small two-state machine that tracks its pending flag. In `PIN_IDLE` no event is waiting. The transition *detect* (`PIN_IDLE` to `PIN_PENDING`) fires when the selected style sees its condition. In `PIN_PENDING` the flag is held. The transition *acknowledge* (`PIN_PENDING` to `PIN_IDLE`) fires on a write-1-to-clear, unless an edge-style event arrives in the same cycle. A level style that is still active re-enters `PIN_PENDING` one cycle after the acknowledge.

The bus is write-strobed. Reads are combinational from the byte address, and only bits [4:2] of the address select a register.

Top module: `gpio16_irq_ctrl`

## Requirements
- R1: After reset, the output data, status and both style registers read 0, the direction register reads 0x0000FFFF, no pin is driven and every interrupt output is low.
- R2: Address 0x00 holds the output data and address 0x04 holds the direction; both read back their lower 16 bits. A direction bit of 1 makes the pin an input (`pad_drive_en` low). A direction bit of 0 drives `pad_out` from the data bit.
- R3: Address 0x08 returns the pin levels through a two-flop synchronizer, so a change on `pin_in` is visible two clock edges later. Bits [31:16] read 0, and writes to this address have no effect.
- R4: Address 0x10 holds the styles of pins 0–7 and address 0x14 holds pins 8–15. The pin at local index n uses bits [3n+2:3n], and bits [31:24] read 0.
- R5: Style code 0 selects level high, 1 level low, 2 rising edge, 3 falling edge and 4 either edge. The pending flag sets on the third clock edge after the pin change. Codes 5–7 never set the flag.
- R6: Address 0x0C reads the 16 pending flags. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R7: An edge-style flag stays set until it is cleared, even if the pin holds its new level. If an edge and a clear of the same bit land in the same cycle, the flag stays set.
- R8: For a level style, a clear takes effect for one cycle, and the flag sets again on the next cycle if the pin is still at its active level.
- R9: `irq_out[i]` for pins 0–12 is high while that pin's flag is set and its style code is 0–4. Pins 13–15 set status bits but raise no output.
- R10: Addresses 0x18 and 0x1C, and any other unmapped word, read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 16 | Asynchronous pin levels |
| pad_out | output | 16 | Output data toward the pads |
| pad_drive_en | output | 16 | 1 where the pad is driven (direction bit 0) |
| irq_out | output | 13 | Level-high interrupts for pins 0–12 |

## Verification
The main function is exercised with a table of pin transitions, each given as a start level and an end level, under all five styles and two unused codes. The transitions alternate between a pin in the lower style register and a pin in the upper one. Pairs such as a rise against a fall under one style show that the correct polarity and edge are decoded. The repeated-level and no-change rows show that a static input raises nothing under an edge style, and that an inactive level raises nothing under a level style. The directed cases then separate the two clear behaviours: an edge that coincides with a clear survives it, while a level flag drops for exactly one cycle and returns.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;

    localparam int unsigned STYLE_W = 3;

    typedef enum logic [STYLE_W-1:0] {
        STY_LVL_HI = 3'd0,
        STY_LVL_LO = 3'd1,
        STY_RISE   = 3'd2,
        STY_FALL   = 3'd3,
        STY_ANY    = 3'd4
    } style_e;

    typedef enum logic {
        PIN_IDLE    = 1'b0,
        PIN_PENDING = 1'b1
    } pend_state_e;

    // word indices (byte address / 4)
    localparam int unsigned OFS_DOUT = 0;
    localparam int unsigned OFS_DIR  = 1;
    localparam int unsigned OFS_PINS = 2;
    localparam int unsigned OFS_STAT = 3;
    localparam int unsigned OFS_STY0 = 4;

endpackage

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio16_pin_event.sv
module gpio16_pin_event
    import gpio16_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lvl_now,
    input  logic               lvl_prev,
    input  logic [STYLE_W-1:0] style,
    input  logic               clr,
    output logic               pending,
    output logic               style_ok
);
    pend_state_e st_q, st_nxt;
    logic        hit;
    logic        edge_sty;
    logic        rise;
    logic        fall;

    assign rise = lvl_now & ~lvl_prev;
    assign fall = ~lvl_now & lvl_prev;

    always_comb begin
        hit      = 1'b0;
        edge_sty = 1'b0;
        unique case (style_e'(style))
            STY_LVL_HI: hit = lvl_now;
            STY_LVL_LO: hit = ~lvl_now;
            STY_RISE:   begin hit = rise;        edge_sty = 1'b1; end
            STY_FALL:   begin hit = fall;        edge_sty = 1'b1; end
            STY_ANY:    begin hit = rise | fall; edge_sty = 1'b1; end
            default:    hit = 1'b0;
        endcase
    end

    // next-state: detect and acknowledge
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            PIN_IDLE:    if (hit) st_nxt = PIN_PENDING;
            PIN_PENDING: if (clr && !(hit && edge_sty)) st_nxt = PIN_IDLE;
            default:     st_nxt = PIN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PIN_IDLE;
        else        st_q <= st_nxt;
    end

    always_comb begin
        pending  = (st_q == PIN_PENDING);
        style_ok = (style <= STY_ANY);
    end
endmodule

// File: rtl/gpio16_irq_ctrl.sv
module gpio16_irq_ctrl
    import gpio16_pkg::*;
#(
    parameter int unsigned NUM_PINS = 16,
    parameter int unsigned NUM_IRQ  = 13,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_drive_en,
    output logic [NUM_IRQ-1:0]  irq_out
);
    localparam int unsigned WORD_W   = ADDR_W - 2;
    localparam int unsigned PER_REG  = 8;
    localparam int unsigned STY_BITS = STYLE_W * PER_REG;
    localparam int unsigned NUM_SREG = NUM_PINS / PER_REG;

    localparam logic [WORD_W-1:0] W_DOUT = WORD_W'(OFS_DOUT);
    localparam logic [WORD_W-1:0] W_DIR  = WORD_W'(OFS_DIR);
    localparam logic [WORD_W-1:0] W_PINS = WORD_W'(OFS_PINS);
    localparam logic [WORD_W-1:0] W_STAT = WORD_W'(OFS_STAT);

    logic [WORD_W-1:0]   word;
    logic [NUM_PINS-1:0] dout_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [STYLE_W-1:0]  style_q [NUM_PINS];
    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] prev_lvl;
    logic [NUM_PINS-1:0] clr_vec;
    logic [NUM_PINS-1:0] pend_vec;
    logic [NUM_PINS-1:0] ok_vec;
    logic [STY_BITS-1:0] sty_word [NUM_SREG];
    logic                unused_bits;

    assign word        = bus_addr[ADDR_W-1:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:STY_BITS]};

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '1;
            for (int p = 0; p < NUM_PINS; p++) style_q[p] <= '0;
        end else if (bus_wr) begin
            if (word == W_DOUT) dout_q <= bus_wdata[NUM_PINS-1:0];
            if (word == W_DIR)  dir_q  <= bus_wdata[NUM_PINS-1:0];
            for (int p = 0; p < NUM_PINS; p++) begin
                if (word == WORD_W'(OFS_STY0 + p / PER_REG))
                    style_q[p] <= bus_wdata[(p % PER_REG) * STYLE_W +: STYLE_W];
            end
        end
    end

    assign pad_out      = dout_q;
    assign pad_drive_en = ~dir_q;

    gpio16_sync #(.WIDTH(NUM_PINS)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_lvl <= '0;
        else        prev_lvl <= sync_lvl;
    end

    assign clr_vec = (bus_wr && word == W_STAT) ? bus_wdata[NUM_PINS-1:0] : '0;

    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
            gpio16_pin_event ev_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .lvl_now  (sync_lvl[g]),
                .lvl_prev (prev_lvl[g]),
                .style    (style_q[g]),
                .clr      (clr_vec[g]),
                .pending  (pend_vec[g]),
                .style_ok (ok_vec[g])
            );
        end
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
            assign irq_out[i] = pend_vec[i] & ok_vec[i];
        end
        for (genvar r = 0; r < NUM_SREG; r++) begin : g_sty
            always_comb begin
                for (int k = 0; k < PER_REG; k++)
                    sty_word[r][k*STYLE_W +: STYLE_W] = style_q[r*PER_REG + k];
            end
        end
    endgenerate

    // read path
    always_comb begin
        bus_rdata = '0;
        case (word)
            W_DOUT:  bus_rdata[NUM_PINS-1:0] = dout_q;
            W_DIR:   bus_rdata[NUM_PINS-1:0] = dir_q;
            W_PINS:  bus_rdata[NUM_PINS-1:0] = sync_lvl;
            W_STAT:  bus_rdata[NUM_PINS-1:0] = pend_vec;
            default: begin
                for (int r = 0; r < NUM_SREG; r++)
                    if (word == WORD_W'(OFS_STY0 + r))
                        bus_rdata[STY_BITS-1:0] = sty_word[r];
            end
        endcase
    end
endmodule

// File: rtl/gpio16_irq_ctrl_chk.sv
module gpio16_irq_ctrl_chk #(
    parameter int unsigned NUM_PINS = 16,
    parameter int unsigned NUM_IRQ  = 13,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_IRQ-1:0]  irq_out,
    input logic [NUM_PINS-1:0] pend_vec
);
    logic [NUM_PINS-1:0] clr_seen;
    logic                is_stat_wr;
    logic                is_dout_wr;
    logic                unused_chk;

    assign is_stat_wr = bus_wr && (bus_addr[ADDR_W-1:2] == 3'd3);
    assign is_dout_wr = bus_wr && (bus_addr[ADDR_W-1:2] == 3'd0);
    assign clr_seen   = is_stat_wr ? bus_wdata[NUM_PINS-1:0] : '0;
    assign unused_chk = ^bus_wdata[DATA_W-1:NUM_PINS];

    AST_STATUS_W1C_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_vec) & ~pend_vec & ~$past(clr_seen)) == '0)); // R6

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~pend_vec[NUM_IRQ-1:0]) == '0)); // R9

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_dout_wr |=> $stable(pad_out)); // R2

    AST_PIN_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[ADDR_W-1:2] == 3'd2 && $past(rst_n) && $past(rst_n, 2))
        |-> bus_rdata == {{(DATA_W-NUM_PINS){1'b0}}, $past(pin_in, 2)}); // R3

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[ADDR_W-1:2] >= 3'd6) |-> bus_rdata == '0); // R10
endmodule

bind gpio16_irq_ctrl gpio16_irq_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .NUM_IRQ  (NUM_IRQ),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pad_out   (pad_out),
    .irq_out   (irq_out),
    .pend_vec  (pend_vec)
);

// File: tb/gpio16_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio16_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_drive_en;
    logic [12:0] irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio16_irq_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pin_in       (pin_in),
        .pad_out      (pad_out),
        .pad_drive_en (pad_drive_en),
        .irq_out      (irq_out)
    );

    // {style[2:0], start level, end level, expected pending}
    localparam logic [5:0] VEC [13] = '{
        6'b000_0_1_1, 6'b000_0_0_0, 6'b001_1_0_1, 6'b001_1_1_0,
        6'b010_0_1_1, 6'b010_1_0_0, 6'b011_1_0_1, 6'b011_0_1_0,
        6'b100_0_1_1, 6'b100_1_0_1, 6'b100_0_0_0, 6'b101_0_1_0,
        6'b111_1_0_0
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] rd;
        wait_cyc(3);
        // R1 reset values
        bus_read(5'h04, rd); check("R1 dir reset", rd, 32'h0000FFFF);
        bus_read(5'h00, rd); check("R1 dout reset", rd, 32'h0);
        bus_read(5'h0C, rd); check("R1 status reset", rd, 32'h0);
        bus_read(5'h14, rd); check("R1 style reset", rd, 32'h0);
        check("R1 drive reset", {16'h0, pad_drive_en}, 32'h0);
        check("R1 irq reset", {19'h0, irq_out}, 32'h0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R2 output data and direction
        bus_write(5'h00, 32'hFFFF_A5C3);
        bus_write(5'h04, 32'hFFFF_00FF);
        check("R2 pad_out", {16'h0, pad_out}, 32'h0000A5C3);
        check("R2 drive_en", {16'h0, pad_drive_en}, 32'h0000FF00);
        bus_read(5'h00, rd); check("R2 dout read", rd, 32'h0000A5C3);
        bus_read(5'h04, rd); check("R2 dir read", rd, 32'h000000FF);
        bus_write(5'h04, 32'h0000FFFF);
        check("R2 all inputs", {16'h0, pad_drive_en}, 32'h0);

        // R3 synchronizer latency and read-only input register
        pin_in = 16'h1234;
        wait_cyc(1);
        bus_read(5'h08, rd); check("R3 one edge", rd, 32'h0);
        wait_cyc(1);
        bus_read(5'h08, rd); check("R3 two edges", rd, 32'h00001234);
        bus_write(5'h08, 32'h0000FFFF);
        bus_read(5'h08, rd); check("R3 write ignored", rd, 32'h00001234);
        pin_in = '0;
        wait_cyc(3);

        // R10 unmapped words
        bus_write(5'h18, 32'hFFFF_FFFF);
        bus_write(5'h1C, 32'hFFFF_FFFF);
        bus_read(5'h18, rd); check("R10 clock ctl word", rd, 32'h0);
        bus_read(5'h1C, rd); check("R10 debounce word", rd, 32'h0);
        bus_read(5'h04, rd); check("R10 no side effect", rd, 32'h0000FFFF);

        // R4 style packing
        bus_write(5'h10, 32'h1234_5678);
        bus_read(5'h10, rd); check("R4 style lo readback", rd, 32'h00345678);
        bus_write(5'h14, 32'hFFFF_FFFF);
        bus_read(5'h14, rd); check("R4 style hi readback", rd, 32'h00FFFFFF);
        bus_write(5'h10, 32'h0);
        bus_write(5'h14, 32'h0);
        bus_write(5'h0C, 32'h0000FFFF);

        // R5 / R9 vector table
        for (int i = 0; i < 13; i++) begin
            int p;
            logic [2:0] code;
            p = (i % 2 == 1) ? 10 : 4;
            code = VEC[i][5:3];
            pin_in = '0;
            pin_in[p] = VEC[i][2];
            wait_cyc(4);
            bus_write((p < 8) ? 5'h10 : 5'h14, 32'(code) << (3 * (p % 8)));
            wait_cyc(2);
            bus_write(5'h0C, 32'h0000FFFF);
            wait_cyc(2);
            pin_in[p] = VEC[i][1];
            wait_cyc(5);
            bus_read(5'h0C, rd);
            check($sformatf("R5 vec%0d status pin%0d", i, p), {31'h0, rd[p]}, {31'h0, VEC[i][0]});
            check($sformatf("R9 vec%0d irq pin%0d", i, p), {31'h0, irq_out[p]}, {31'h0, VEC[i][0]});
        end
        pin_in = '0;
        bus_write(5'h10, 32'h0);
        bus_write(5'h14, 32'h0);
        wait_cyc(3);
        bus_write(5'h0C, 32'h0000FFFF);

        // R7 edge beats a coincident clear; R6 zero writes
        bus_write(5'h10, 32'h0001_0000);          // pin 5 rising
        wait_cyc(2);
        pin_in = 16'h0020;
        wait_cyc(2);
        bus_wr = 1'b1; bus_addr = 5'h0C; bus_wdata = 32'h20;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(5'h0C, rd); check("R7 edge wins clear", rd, 32'h00000020);
        check("R9 irq pin5", {19'h0, irq_out}, 32'h00000020);
        bus_write(5'h0C, 32'h0);
        bus_read(5'h0C, rd); check("R6 zero write keeps", rd, 32'h00000020);
        bus_write(5'h0C, 32'h20);
        bus_read(5'h0C, rd); check("R6 one write clears", rd, 32'h0);
        wait_cyc(3);
        bus_read(5'h0C, rd); check("R7 held level no re-set", rd, 32'h0);

        // R8 level flag drops for one cycle
        bus_write(5'h10, 32'h0);
        pin_in = 16'h0040;
        wait_cyc(4);
        bus_write(5'h0C, 32'h0000FFFF);
        bus_read(5'h0C, rd); check("R8 cleared cycle", rd, 32'h0);
        wait_cyc(1);
        bus_read(5'h0C, rd); check("R8 returns", rd, 32'h00000040);

        // R9 pins 13-15 status only
        pin_in = '0;
        bus_write(5'h14, 32'h0049_0000);
        wait_cyc(3);
        bus_write(5'h0C, 32'h0000FFFF);
        pin_in = 16'hE000;
        wait_cyc(4);
        bus_read(5'h0C, rd); check("R9 upper pins status", rd, 32'h0000E000);
        check("R9 upper pins no irq", {19'h0, irq_out}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule